// File: doc/BRIEF.md
# Segmented Linear Address Generator

This block turns a memory reference into a 64-bit linear address, following the rules of the processor mode in force. A request gives a mode, a segment identifier, a 16-bit selector and an effective address. In real and virtual-8086 modes, the selector value is shifted left by four and added to the low 16 bits of the effective address. In protected and compatibility modes, the low 32 bits of the segment base are added to the low 32 bits of the effective address. In 64-bit mode, only the two general-purpose base segments contribute a base. Every other segment uses a base of zero, and the result must pass a canonical-form test.

Software loads the six segment bases through a one-write-per-cycle port. The bases are used as given: there is no descriptor-table lookup, no limit or privilege check and no paging. One cycle after a request, the block gives either a valid strobe or a fault strobe, together with the computed address.

Top module: `seg_lin_addr`

## Requirements
- R1: After reset, valid_o, fault_o and lin_addr_o are zero, and all six segment bases read as zero.
- R2: In mode code 0 (real), lin_addr_o = ({sel_i, 4'h0} + ea_i[15:0]) mod 2^20, with bits 63:20 zero. The segment bases and ea_i[63:16] have no effect.
- R3: In mode code 1 (virtual-8086), the address is formed exactly as in R2.
- R4: In mode code 2 (protected), lin_addr_o = (base[31:0] + ea_i[31:0]) mod 2^32, with bits 63:32 zero. Here base is the base of seg_i, or zero when seg_i is 6 or 7.
- R5: In mode code 3 (compatibility), the address is formed exactly as in R4.
- R6: In mode code 4 (64-bit), segment codes 0 (ES), 1 (CS), 2 (SS) and 3 (DS) use a zero base, so lin_addr_o = ea_i whatever the loaded bases hold. Codes 6 and 7 also use a zero base.
- R7: In mode code 4, segment codes 4 (FS) and 5 (GS) give lin_addr_o = (base + ea_i) mod 2^64.
- R8: In mode code 4, a result whose bits 63:47 are not all equal sets fault_o and clears valid_o. lin_addr_o still shows the sum.
- R9: valid_o or fault_o pulses in the cycle after req_i is sampled high, never both at once. Both are low after a cycle without a request.
- R10: When base_we_i is high at a clock edge, the base of segment base_sel_i (codes 0 to 5) takes base_wdata_i. A request in the same cycle still uses the previous value.
- R11: Mode codes 5 to 7 are reserved. A request in one of them sets fault_o, clears valid_o and gives lin_addr_o = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| base_we_i | input | 1 | Base register write enable |
| base_sel_i | input | 3 | Segment code of the base being written |
| base_wdata_i | input | 64 | Base value to write |
| req_i | input | 1 | Address request strobe |
| mode_i | input | 3 | Processor mode code |
| seg_i | input | 3 | Segment code of the reference |
| sel_i | input | 16 | Selector / segment value |
| ea_i | input | 64 | Effective address |
| lin_addr_o | output | 64 | Registered linear address |
| valid_o | output | 1 | Address is valid |
| fault_o | output | 1 | Non-canonical address or reserved mode |

## Verification
The real-mode patterns use a selector and offset both at 0xFFFF, which shows whether the 20-bit result wraps or leaks into bit 20. The 32-bit patterns place a base near the top of the 4 GB space, which tells a modulo-2^32 sum apart from a 64-bit one, and set the upper effective-address bits to check that they are dropped. In 64-bit mode, the segments with a forced zero base are exercised after nonzero bases have been loaded, so an ignored base cannot be mistaken for a zero one. Addresses just inside and just outside each canonical half, and a sum that wraps past 2^64, separate the canonical test from the plain addition. Random mixes of all modes, all segment codes and interleaved base writes cover the remaining combinations.

// File: rtl/seg_lin_addr_pkg.sv
`timescale 1ns/1ps
package seg_lin_addr_pkg;
  localparam int ADDR_W    = 64;
  localparam int VA_W      = 48;
  localparam int SEL_W     = 16;
  localparam int RM_SHIFT  = 4;
  localparam int PM_W      = 32;
  localparam int NUM_SEG   = 6;
  localparam int SEG_IDX_W = 3;
  localparam int MODE_W    = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_REAL   = 3'd0,
    MODE_V86    = 3'd1,
    MODE_PROT   = 3'd2,
    MODE_COMPAT = 3'd3,
    MODE_LONG   = 3'd4
  } cpu_mode_e;

  typedef enum logic [SEG_IDX_W-1:0] {
    SEG_ES = 3'd0,
    SEG_CS = 3'd1,
    SEG_SS = 3'd2,
    SEG_DS = 3'd3,
    SEG_FS = 3'd4,
    SEG_GS = 3'd5
  } seg_id_e;
endpackage

// File: rtl/seg_base_regs.sv
`timescale 1ns/1ps
module seg_base_regs
  import seg_lin_addr_pkg::*;
#(
  parameter int N_SEG  = NUM_SEG,
  parameter int IDX_W  = SEG_IDX_W,
  parameter int DATA_W = ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  wr_seg_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  rd_seg_i,
  output logic [DATA_W-1:0] rd_base_o
);
  logic [DATA_W-1:0] base_q [N_SEG];

  for (genvar g = 0; g < N_SEG; g++) begin : g_seg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                base_q[g] <= '0;
      else if (we_i && wr_seg_i == IDX_W'(g))     base_q[g] <= wdata_i;
    end

    // R10: addressed base takes the written value
    a_r10_base_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && wr_seg_i == IDX_W'(g)) |=> base_q[g] == $past(wdata_i));
  end

  // codes beyond the last segment read as zero
  always_comb begin
    rd_base_o = '0;
    for (int i = 0; i < N_SEG; i++) begin
      if (rd_seg_i == IDX_W'(i)) rd_base_o = base_q[i];
    end
  end
endmodule

// File: rtl/seg_addr_calc.sv
`timescale 1ns/1ps
module seg_addr_calc
  import seg_lin_addr_pkg::*;
#(
  parameter int AW     = ADDR_W,
  parameter int SW     = SEL_W,
  parameter int SHIFT  = RM_SHIFT,
  parameter int PW     = PM_W,
  parameter int IDX_W  = SEG_IDX_W,
  parameter int MW     = MODE_W
) (
  input  logic [MW-1:0]    mode_i,
  input  logic [IDX_W-1:0] seg_i,
  input  logic [SW-1:0]    sel_i,
  input  logic [AW-1:0]    ea_i,
  input  logic [AW-1:0]    base_i,
  output logic [AW-1:0]    addr_o,
  output logic             chk_canon_o,
  output logic             bad_mode_o
);
  localparam int RW = SW + SHIFT;

  logic [RW-1:0] rm_sum;
  logic [PW-1:0] pm_sum;
  logic [AW-1:0] lm_base;
  logic [AW-1:0] lm_sum;
  logic          seg_has_base;

  assign rm_sum       = {sel_i, {SHIFT{1'b0}}} + RW'(ea_i[SW-1:0]);
  assign pm_sum       = base_i[PW-1:0] + ea_i[PW-1:0];
  assign seg_has_base = (seg_i == SEG_FS) || (seg_i == SEG_GS);
  assign lm_base      = seg_has_base ? base_i : '0;
  assign lm_sum       = lm_base + ea_i;

  always_comb begin
    addr_o      = '0;
    chk_canon_o = 1'b0;
    bad_mode_o  = 1'b0;
    case (mode_i)
      MODE_REAL, MODE_V86:   addr_o = AW'(rm_sum);
      MODE_PROT, MODE_COMPAT: addr_o = AW'(pm_sum);
      MODE_LONG: begin
        addr_o      = lm_sum;
        chk_canon_o = 1'b1;
      end
      default:               bad_mode_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/seg_canon_chk.sv
`timescale 1ns/1ps
module seg_canon_chk
  import seg_lin_addr_pkg::*;
#(
  parameter int AW  = ADDR_W,
  parameter int VAW = VA_W
) (
  input  logic [AW-VAW:0] hi_i,   // address bits AW-1 down to VAW-1
  output logic            canon_o
);
  assign canon_o = (&hi_i) | ~(|hi_i);
endmodule

// File: rtl/seg_lin_addr.sv
`timescale 1ns/1ps
module seg_lin_addr
  import seg_lin_addr_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 base_we_i,
  input  logic [SEG_IDX_W-1:0] base_sel_i,
  input  logic [ADDR_W-1:0]    base_wdata_i,
  input  logic                 req_i,
  input  logic [MODE_W-1:0]    mode_i,
  input  logic [SEG_IDX_W-1:0] seg_i,
  input  logic [SEL_W-1:0]     sel_i,
  input  logic [ADDR_W-1:0]    ea_i,
  output logic [ADDR_W-1:0]    lin_addr_o,
  output logic                 valid_o,
  output logic                 fault_o
);
  logic [ADDR_W-1:0] seg_base;
  logic [ADDR_W-1:0] addr_d;
  logic              chk_canon;
  logic              bad_mode;
  logic              canon;
  logic              fault_d;
  logic              valid_d;

  seg_base_regs u_bases (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (base_we_i),
    .wr_seg_i  (base_sel_i),
    .wdata_i   (base_wdata_i),
    .rd_seg_i  (seg_i),
    .rd_base_o (seg_base)
  );

  seg_addr_calc u_calc (
    .mode_i      (mode_i),
    .seg_i       (seg_i),
    .sel_i       (sel_i),
    .ea_i        (ea_i),
    .base_i      (seg_base),
    .addr_o      (addr_d),
    .chk_canon_o (chk_canon),
    .bad_mode_o  (bad_mode)
  );

  seg_canon_chk u_canon (
    .hi_i    (addr_d[ADDR_W-1:VA_W-1]),
    .canon_o (canon)
  );

  assign fault_d = req_i & (bad_mode | (chk_canon & ~canon));
  assign valid_d = req_i & ~fault_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lin_addr_o <= '0;
      valid_o    <= 1'b0;
      fault_o    <= 1'b0;
    end else begin
      valid_o <= valid_d;
      fault_o <= fault_d;
      if (req_i) lin_addr_o <= addr_d;
    end
  end

  a_r9_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && fault_o));

  a_r9_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o || fault_o) |-> $past(req_i));

  a_r9_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> (!valid_o && !fault_o));

  a_r2_real_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && (mode_i == MODE_REAL || mode_i == MODE_V86))
      |=> (valid_o && lin_addr_o[ADDR_W-1:SEL_W+RM_SHIFT] == '0));

  a_r4_prot_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && (mode_i == MODE_PROT || mode_i == MODE_COMPAT))
      |=> (valid_o && lin_addr_o[ADDR_W-1:PM_W] == '0));

  a_r8_fault_noncanon: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && mode_i == MODE_LONG) |=>
      (fault_o == !((&lin_addr_o[ADDR_W-1:VA_W-1]) || !(|lin_addr_o[ADDR_W-1:VA_W-1]))));

  a_r11_reserved: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && mode_i > MODE_LONG) |=> (fault_o && lin_addr_o == '0));
endmodule

// File: tb/seg_lin_addr_test.sv
`timescale 1ns/1ps
module seg_lin_addr_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_we = 1'b0;
  logic [2:0]  base_sel = '0;
  logic [63:0] base_wdata = '0;
  logic        req = 1'b0;
  logic [2:0]  mode = '0;
  logic [2:0]  seg = '0;
  logic [15:0] sel = '0;
  logic [63:0] ea = '0;
  logic [63:0] lin_addr;
  logic        valid;
  logic        fault;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;
  logic [63:0] mb [8];

  always #4 clk = ~clk;

  seg_lin_addr uut (
    .clk_i(clk), .rst_ni(rst_n),
    .base_we_i(base_we), .base_sel_i(base_sel), .base_wdata_i(base_wdata),
    .req_i(req), .mode_i(mode), .seg_i(seg), .sel_i(sel), .ea_i(ea),
    .lin_addr_o(lin_addr), .valid_o(valid), .fault_o(fault)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic void model(input logic [2:0] m, input logic [2:0] s,
                                input logic [15:0] sl, input logic [63:0] e,
                                output logic [63:0] a, output logic f);
    logic [19:0] r;
    logic [31:0] p;
    logic [63:0] b;
    f = 1'b0;
    a = '0;
    case (m)
      3'd0, 3'd1: begin r = {sl, 4'h0} + {4'h0, e[15:0]}; a = {44'h0, r}; end
      3'd2, 3'd3: begin p = mb[s][31:0] + e[31:0]; a = {32'h0, p}; end
      3'd4: begin
        b = (s == 3'd4 || s == 3'd5) ? mb[s] : 64'h0;
        a = b + e;
        f = !((a[63:47] == 17'h1ffff) || (a[63:47] == 17'h0));
      end
      default: f = 1'b1;
    endcase
  endfunction

  task automatic wr_base(input logic [2:0] s, input logic [63:0] d);
    @(negedge clk);
    base_we = 1'b1; base_sel = s; base_wdata = d;
    @(negedge clk);
    base_we = 1'b0;
    mb[s] = d;
  endtask

  task automatic do_req(input logic [2:0] m, input logic [2:0] s,
                        input logic [15:0] sl, input logic [63:0] e, input string tag);
    logic [63:0] ea_x;
    logic f_x;
    model(m, s, sl, e, ea_x, f_x);
    @(negedge clk);
    req = 1'b1; mode = m; seg = s; sel = sl; ea = e;
    @(negedge clk);
    req = 1'b0;
    chk({tag, " addr"}, lin_addr, ea_x);
    chk({tag, " valid"}, {63'h0, valid}, {63'h0, ~f_x});
    chk(f_x ? {tag, "/R8 fault"} : {tag, " fault"}, {63'h0, fault}, {63'h0, f_x});
    @(negedge clk);
    chk("R9 idle strobes", {62'h0, valid, fault}, 64'h0);
  endtask

  function automatic string tag_of(input logic [2:0] m);
    case (m)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R7";
      default: return "R11";
    endcase
  endfunction

  initial begin
    for (int i = 0; i < 8; i++) mb[i] = '0;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk("R1 reset addr", lin_addr, 64'h0);
    chk("R1 reset strobes", {62'h0, valid, fault}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 strobes after reset", {62'h0, valid, fault}, 64'h0);
    do_req(3'd4, 3'd4, 16'h0, 64'h0, "R1 FS base zero");
    do_req(3'd2, 3'd5, 16'h0, 64'h0, "R1 GS base zero");

    // real / v86 with loaded bases that must be ignored
    wr_base(3'd3, 64'h1234_5678_9abc_def0);
    do_req(3'd0, 3'd3, 16'hffff, 64'hdead_beef_0000_ffff, "R2 wrap 1MB");
    do_req(3'd0, 3'd3, 16'h1234, 64'h0000_0000_0000_0010, "R2 shift add");
    do_req(3'd1, 3'd3, 16'hffff, 64'h0000_0000_0000_ffff, "R3 wrap 1MB");
    do_req(3'd1, 3'd0, 16'h0abc, 64'h0000_0000_0001_0005, "R3 offset trunc");

    // 32-bit modes
    wr_base(3'd1, 64'haaaa_bbbb_ffff_fff0);
    do_req(3'd2, 3'd1, 16'h0, 64'h5555_0000_0000_0020, "R4 wrap 4GB");
    do_req(3'd3, 3'd1, 16'h0, 64'h0000_0000_0000_0005, "R5 compat");
    do_req(3'd3, 3'd7, 16'h0, 64'h0000_0001_8000_0000, "R5 seg code 7");

    // 64-bit, forced zero bases
    wr_base(3'd0, 64'h1111); wr_base(3'd2, 64'h2222);
    do_req(3'd4, 3'd0, 16'h0, 64'h0000_1234_5678_9abc, "R6 ES zero base");
    do_req(3'd4, 3'd1, 16'h0, 64'hffff_8000_0000_0000, "R6 CS zero base");
    do_req(3'd4, 3'd2, 16'h0, 64'h0000_7fff_ffff_ffff, "R6 SS top low half");
    do_req(3'd4, 3'd3, 16'h0, 64'h0000_8000_0000_0000, "R6/R8 DS non-canonical");
    do_req(3'd4, 3'd6, 16'h0, 64'hffff_7fff_ffff_ffff, "R6/R8 code 6");

    // FS / GS
    wr_base(3'd4, 64'h0000_7fff_ffff_fff0);
    do_req(3'd4, 3'd4, 16'h0, 64'h20, "R7/R8 FS crosses");
    do_req(3'd4, 3'd4, 16'h0, 64'h0f, "R7 FS edge");
    wr_base(3'd5, 64'hffff_ffff_ffff_ffff);
    do_req(3'd4, 3'd5, 16'h0, 64'h2, "R7 GS wrap 2^64");

    // reserved modes
    do_req(3'd5, 3'd4, 16'h1, 64'h1, "R11 mode 5");
    do_req(3'd7, 3'd0, 16'h1, 64'h1, "R11 mode 7");

    // R10: write in same cycle as request uses old base
    @(negedge clk);
    base_we = 1'b1; base_sel = 3'd4; base_wdata = 64'h1000;
    req = 1'b1; mode = 3'd4; seg = 3'd4; ea = 64'h1;
    @(negedge clk);
    base_we = 1'b0; req = 1'b0;
    chk("R10 same-cycle old base", lin_addr, 64'h0000_7fff_ffff_fff1);
    mb[4] = 64'h1000;
    do_req(3'd4, 3'd4, 16'h0, 64'h1, "R10 new base");

    // random mix
    for (int it = 0; it < 600; it++) begin
      logic [2:0]  m, s;
      logic [63:0] e, d;
      if ($urandom_range(0, 7) == 0) begin
        d = {$urandom, $urandom};
        if ($urandom_range(0, 1) == 1) d = {{16{d[47]}}, d[47:0]};
        wr_base(3'($urandom_range(0, 5)), d);
      end
      m = 3'($urandom_range(0, 7));
      s = 3'($urandom_range(0, 7));
      e = {$urandom, $urandom};
      if (m == 3'd4 && $urandom_range(0, 2) != 0) e = {{16{e[46]}}, e[47:0]};
      do_req(m, s, 16'($urandom), e, tag_of(m));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule